// File: doc/BRIEF.md
# Peripheral Clock Mask Controller

This block holds the clock-enable bits for a group of on-chip peripherals in two 16-bit registers. It drives those bits straight out to the clock gates. A command port changes them one peripheral at a time. Each command carries an operation, either supply (turn the clock on) or mask (turn it off), and a peripheral identifier. The block turns that command into the right set of enable bits. Several peripherals own more than one bit. One bit is shared by the main serial unit and the debug serial unit.

A mode input chooses between two variants. In the legacy variant the shared bit belongs to the main serial unit alone, and the second register does not exist. In the newer variant the debug serial unit also needs the shared bit. Masking either serial unit then leaves the shared bit set while the other unit still runs.

A small register port lets software read either register and overwrite it directly. Register 0 sits at offset 0 and register 1 at offset 4.

Top module: `clkmask_ctrl`

## Requirements
- R1: While `rst` is high, both enable registers are cleared to zero at each rising clock edge. After reset, every clock is masked, and both registers read as zero.
- R2: Single-bit peripherals set their own bit on supply (`cmd_supply`=1) and clear it on mask (`cmd_supply`=0). No other bit changes. The identifiers and register-0 bits are: touch id 0 bit 0, audio id 2 bit 2, keypad id 3 bit 3, PCI host id 7 bit 7, modem id 8 bit 9, PCI bus clock id 9 bit 13.
- R3: Paired peripherals change both of their bits together, on supply and on mask. These are infrared id 4 (bits 4 and 10) and clocked serial id 6 (bits 6 and 12). Supplying the main serial unit, id 1, sets bits 1 and 8.
- R4: Supplying the debug serial unit, id 5, sets bits 5 and 11. In the newer variant (`legacy_mode`=0) it also sets the shared bit 1. In the legacy variant it leaves bit 1 unchanged.
- R5: Masking the main serial unit, id 1, clears bits 1 and 8 in the legacy variant. In the newer variant, bit 1 is kept if bit 5 or bit 11 is set, and only bit 8 is cleared.
- R6: Masking the debug serial unit, id 5, clears bits 5 and 11. In the newer variant it also clears bit 1, but only when bit 8 is already clear.
- R7: Camera id 10, Ethernet 0 id 11 and Ethernet 1 id 12 change register 1 only, at bits 0, 1 and 2. Register 0 stays unchanged for these ids. All other recognised ids change register 0 only.
- R8: A command with identifier 13, 14 or 15 leaves both registers unchanged.
- R9: A command with `cmd_valid` high changes the enable outputs at the next rising edge. With `cmd_valid` low and no register write, the registers hold their value.
- R10: While `legacy_mode` is 1, register 1 is cleared, reads as zero and ignores both commands and direct writes.
- R11: `reg_rdata` shows register 0 when `reg_addr` is 0 and register 1 when `reg_addr` is 4. It reads zero for any other address, with no added delay. A write (`reg_wr`=1) stores `reg_wdata` into the addressed register at the next edge. A write to any other address changes nothing.
- R12: When `reg_wr` and `cmd_valid` are both high in the same cycle, the register write takes effect and the command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 selects the legacy variant, 0 the newer variant |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_supply | input | 1 | 1 = supply (enable), 0 = mask (disable) |
| cmd_id | input | 4 | Peripheral clock identifier |
| reg_wr | input | 1 | Direct register write strobe |
| reg_addr | input | 3 | Register byte offset (0 or 4) |
| reg_wdata | input | 16 | Direct write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| clk_en0 | output | 16 | Register 0 enable bits |
| clk_en1 | output | 16 | Register 1 enable bits |

## Verification
A command or a register write changes `clk_en0` and `clk_en1` exactly one rising edge after it is presented. Read data follows `reg_addr` within the same cycle. The bench drives each stimulus at a falling edge and clears it at the next falling edge. It compares the outputs at that second falling edge, halfway past the single register stage. The shared-bit rules are exercised by running the same supply and mask sequences of the two serial units in both variants and in both orders.

// File: rtl/clkmask_pkg.sv
`timescale 1ns/1ps
package clkmask_pkg;
   localparam int CLK_ID_W = 4;

   typedef enum logic [CLK_ID_W-1:0] {
      CLK_TOUCH   = 4'd0,
      CLK_UART    = 4'd1,
      CLK_AUDIO   = 4'd2,
      CLK_KEYPAD  = 4'd3,
      CLK_IRDA    = 4'd4,
      CLK_DBGSER  = 4'd5,
      CLK_CSER    = 4'd6,
      CLK_PCIHOST = 4'd7,
      CLK_MODEM   = 4'd8,
      CLK_PCIBUS  = 4'd9,
      CLK_CAM     = 4'd10,
      CLK_ETH0    = 4'd11,
      CLK_ETH1    = 4'd12
   } clk_id_e;

   // register 0 bit positions
   localparam int B_TOUCH    = 0;
   localparam int B_UART     = 1;   // shared with debug serial in newer variant
   localparam int B_AUDIO    = 2;
   localparam int B_KEYPAD   = 3;
   localparam int B_IRDA     = 4;
   localparam int B_DBG_LO   = 5;
   localparam int B_CSER     = 6;
   localparam int B_PCIHOST  = 7;
   localparam int B_UART_AUX = 8;
   localparam int B_MODEM    = 9;
   localparam int B_IRDA_FST = 10;
   localparam int B_DBG_HI   = 11;
   localparam int B_CSER_AUX = 12;
   localparam int B_PCIBUS   = 13;
   localparam int B_TOP0     = 13;

   // register 1 bit positions
   localparam int B_CAM  = 0;
   localparam int B_ETH0 = 1;
   localparam int B_ETH1 = 2;
endpackage

// File: rtl/clkmask_rules.sv
`timescale 1ns/1ps
module clkmask_rules
   import clkmask_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic                legacy,
   input  logic                op_supply,
   input  logic [CLK_ID_W-1:0] id,
   input  logic [REG_W-1:0]    cur0,
   input  logic [REG_W-1:0]    cur1,
   output logic [REG_W-1:0]    nxt0,
   output logic [REG_W-1:0]    nxt1
);
   logic [REG_W-1:0] m0, m1;
   logic             dbg_on, aux_on;

   assign dbg_on = cur0[B_DBG_LO] | cur0[B_DBG_HI];
   assign aux_on = cur0[B_UART_AUX];

   always_comb begin
      m0 = '0;
      m1 = '0;
      case (id)
         CLK_TOUCH:   m0[B_TOUCH]   = 1'b1;
         CLK_UART:    begin m0[B_UART] = 1'b1; m0[B_UART_AUX] = 1'b1; end
         CLK_AUDIO:   m0[B_AUDIO]   = 1'b1;
         CLK_KEYPAD:  m0[B_KEYPAD]  = 1'b1;
         CLK_IRDA:    begin m0[B_IRDA] = 1'b1; m0[B_IRDA_FST] = 1'b1; end
         CLK_DBGSER:  begin m0[B_DBG_LO] = 1'b1; m0[B_DBG_HI] = 1'b1; end
         CLK_CSER:    begin m0[B_CSER] = 1'b1; m0[B_CSER_AUX] = 1'b1; end
         CLK_PCIHOST: m0[B_PCIHOST] = 1'b1;
         CLK_MODEM:   m0[B_MODEM]   = 1'b1;
         CLK_PCIBUS:  m0[B_PCIBUS]  = 1'b1;
         CLK_CAM:     m1[B_CAM]     = 1'b1;
         CLK_ETH0:    m1[B_ETH0]    = 1'b1;
         CLK_ETH1:    m1[B_ETH1]    = 1'b1;
         default:     ;
      endcase

      // shared serial bit handling in the newer variant
      if (!legacy) begin
         if (op_supply && id == CLK_DBGSER)
            m0[B_UART] = 1'b1;
         if (!op_supply && id == CLK_UART && dbg_on)
            m0[B_UART] = 1'b0;
         if (!op_supply && id == CLK_DBGSER && !aux_on)
            m0[B_UART] = 1'b1;
      end

      nxt0 = op_supply ? (cur0 | m0) : (cur0 & ~m0);
      nxt1 = op_supply ? (cur1 | m1) : (cur1 & ~m1);
   end
endmodule

// File: rtl/clkmask_bank.sv
`timescale 1ns/1ps
module clkmask_bank #(
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 3,
   parameter int REG1_ADDR = 4,
   parameter bit HAS_REG1  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              legacy,
   input  logic              cmd_fire,
   input  logic [REG_W-1:0]  cmd_nxt0,
   input  logic [REG_W-1:0]  cmd_nxt1,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  q0,
   output logic [REG_W-1:0]  q1
);
   localparam logic [ADDR_W-1:0] A0 = '0;
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(REG1_ADDR);

   logic sel0, sel1;
   assign sel0 = (addr == A0);
   assign sel1 = (addr == A1);

   always_ff @(posedge clk) begin
      if (rst)
         q0 <= '0;
      else if (wr) begin
         if (sel0)
            q0 <= wdata;
      end else if (cmd_fire)
         q0 <= cmd_nxt0;
   end

   generate
      if (HAS_REG1) begin : g_reg1
         always_ff @(posedge clk) begin
            if (rst || legacy)
               q1 <= '0;
            else if (wr) begin
               if (sel1)
                  q1 <= wdata;
            end else if (cmd_fire)
               q1 <= cmd_nxt1;
         end
      end else begin : g_no_reg1
         assign q1 = '0;
      end
   endgenerate

   always_comb begin
      if (sel0)
         rdata = q0;
      else if (sel1 && !legacy)
         rdata = q1;
      else
         rdata = '0;
   end
endmodule

// File: rtl/clkmask_ctrl.sv
`timescale 1ns/1ps
module clkmask_ctrl
   import clkmask_pkg::*;
#(
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 3,
   parameter int REG1_ADDR = 4,
   parameter bit HAS_REG1  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              legacy_mode,
   input  logic              cmd_valid,
   input  logic              cmd_supply,
   input  logic [3:0]        cmd_id,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [REG_W-1:0]  clk_en0,
   output logic [REG_W-1:0]  clk_en1
);
   generate
      if (REG_W <= B_TOP0) begin : g_bad_width
         $error("clkmask_ctrl: REG_W too narrow for register 0 map");
      end
      if (REG1_ADDR <= 0 || REG1_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("clkmask_ctrl: REG1_ADDR outside address range");
      end
   endgenerate

   logic [REG_W-1:0] nxt0, nxt1;

   clkmask_rules #(.REG_W(REG_W)) u_rules (
      .legacy    (legacy_mode),
      .op_supply (cmd_supply),
      .id        (cmd_id),
      .cur0      (clk_en0),
      .cur1      (clk_en1),
      .nxt0      (nxt0),
      .nxt1      (nxt1)
   );

   clkmask_bank #(
      .REG_W     (REG_W),
      .ADDR_W    (ADDR_W),
      .REG1_ADDR (REG1_ADDR),
      .HAS_REG1  (HAS_REG1)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .legacy   (legacy_mode),
      .cmd_fire (cmd_valid),
      .cmd_nxt0 (nxt0),
      .cmd_nxt1 (nxt1),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .q0       (clk_en0),
      .q1       (clk_en1)
   );
endmodule

// File: rtl/clkmask_ctrl_chk.sv
`timescale 1ns/1ps
module clkmask_ctrl_chk #(
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 3,
   parameter int REG1_ADDR = 4,
   parameter bit HAS_REG1  = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              legacy_mode,
   input logic              cmd_valid,
   input logic              cmd_supply,
   input logic [3:0]        cmd_id,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic [REG_W-1:0]  clk_en0,
   input logic [REG_W-1:0]  clk_en1
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (clk_en0 == '0 && clk_en1 == '0)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!cmd_valid && !reg_wr) |=> $stable(clk_en0)); // R9

   AST_UNKNOWN_ID: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !reg_wr && !legacy_mode && cmd_id >= 4'd13)
      |=> ($stable(clk_en0) && $stable(clk_en1))); // R8

   AST_REG1_CMD_ONLY: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !reg_wr && cmd_id >= 4'd10 && cmd_id <= 4'd12)
      |=> $stable(clk_en0)); // R7

   AST_LEGACY_R1_ZERO: assert property (@(posedge clk) disable iff (rst)
      legacy_mode |=> (clk_en1 == '0)); // R10

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == '0) |=> (clk_en0 == $past(reg_wdata))); // R12

   generate
      if (HAS_REG1) begin : g_r1chk
         AST_REG1_WRITE: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && !legacy_mode && reg_addr == ADDR_W'(REG1_ADDR))
            |=> (clk_en1 == $past(reg_wdata))); // R11
      end
   endgenerate
endmodule

bind clkmask_ctrl clkmask_ctrl_chk #(
   .REG_W     (REG_W),
   .ADDR_W    (ADDR_W),
   .REG1_ADDR (REG1_ADDR),
   .HAS_REG1  (HAS_REG1)
) u_chk (.*);

// File: tb/clkmask_ctrl_test.sv
`timescale 1ns/1ps
module clkmask_ctrl_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        legacy_mode = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_supply = 1'b0;
   logic [3:0]  cmd_id = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata, clk_en0, clk_en1;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   clkmask_ctrl uut (
      .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
      .cmd_valid(cmd_valid), .cmd_supply(cmd_supply), .cmd_id(cmd_id),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .clk_en0(clk_en0), .clk_en1(clk_en1)
   );

   // {legacy, supply, id, expected reg0, expected reg1}, applied in order
   localparam logic [37:0] VEC [0:30] = '{
      {1'b0, 1'b1, 4'd0,  16'h0001, 16'h0000},
      {1'b0, 1'b1, 4'd1,  16'h0103, 16'h0000},
      {1'b0, 1'b1, 4'd5,  16'h0923, 16'h0000},
      {1'b0, 1'b0, 4'd1,  16'h0823, 16'h0000},
      {1'b0, 1'b0, 4'd5,  16'h0001, 16'h0000},
      {1'b0, 1'b1, 4'd1,  16'h0103, 16'h0000},
      {1'b0, 1'b1, 4'd5,  16'h0923, 16'h0000},
      {1'b0, 1'b0, 4'd5,  16'h0103, 16'h0000},
      {1'b0, 1'b0, 4'd1,  16'h0001, 16'h0000},
      {1'b0, 1'b1, 4'd4,  16'h0411, 16'h0000},
      {1'b0, 1'b1, 4'd6,  16'h1451, 16'h0000},
      {1'b0, 1'b1, 4'd7,  16'h14D1, 16'h0000},
      {1'b0, 1'b1, 4'd8,  16'h16D1, 16'h0000},
      {1'b0, 1'b1, 4'd9,  16'h36D1, 16'h0000},
      {1'b0, 1'b1, 4'd2,  16'h36D5, 16'h0000},
      {1'b0, 1'b1, 4'd3,  16'h36DD, 16'h0000},
      {1'b0, 1'b1, 4'd14, 16'h36DD, 16'h0000},
      {1'b0, 1'b1, 4'd10, 16'h36DD, 16'h0001},
      {1'b0, 1'b1, 4'd12, 16'h36DD, 16'h0005},
      {1'b0, 1'b1, 4'd11, 16'h36DD, 16'h0007},
      {1'b0, 1'b0, 4'd11, 16'h36DD, 16'h0005},
      {1'b0, 1'b0, 4'd4,  16'h32CD, 16'h0005},
      {1'b0, 1'b0, 4'd6,  16'h228D, 16'h0005},
      {1'b0, 1'b0, 4'd0,  16'h228C, 16'h0005},
      {1'b0, 1'b0, 4'd15, 16'h228C, 16'h0005},
      {1'b1, 1'b1, 4'd5,  16'h2AAC, 16'h0000},
      {1'b1, 1'b1, 4'd1,  16'h2BAE, 16'h0000},
      {1'b1, 1'b0, 4'd1,  16'h2AAC, 16'h0000},
      {1'b1, 1'b1, 4'd1,  16'h2BAE, 16'h0000},
      {1'b1, 1'b0, 4'd5,  16'h238E, 16'h0000},
      {1'b1, 1'b1, 4'd10, 16'h238E, 16'h0000}
   };

   function automatic string req_of(input logic sup, input logic [3:0] id);
      if (id >= 4'd13) return "R8";
      if (id >= 4'd10) return "R7";
      if (id == 4'd1)  return sup ? "R3" : "R5";
      if (id == 4'd5)  return sup ? "R4" : "R6";
      if (id == 4'd4 || id == 4'd6) return "R3";
      return "R2";
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_cmd(input logic leg, input logic sup, input logic [3:0] id);
      @(negedge clk);
      legacy_mode = leg; cmd_valid = 1'b1; cmd_supply = sup; cmd_id = id;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] a, input logic [15:0] d,
                           input logic with_cmd, input logic [3:0] id);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cmd_valid = with_cmd; cmd_supply = 1'b1; cmd_id = id;
      @(negedge clk);
      reg_wr = 1'b0; cmd_valid = 1'b0;
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] hold0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check("R1", "en0 after reset", clk_en0, 16'h0000);
      check("R1", "en1 after reset", clk_en1, 16'h0000);
      reg_addr = 3'd4; #0.1;
      check("R1", "read reg1 after reset", reg_rdata, 16'h0000);
      reg_addr = 3'd0;

      // table walk: each row due one edge after its command
      for (int i = 0; i < 31; i++) begin
         logic [37:0] v;
         v = VEC[i];
         do_cmd(v[37], v[36], v[35:32]);
         check(req_of(v[36], v[35:32]), $sformatf("row %0d reg0", i), clk_en0, v[31:16]);
         check(v[37] ? "R10" : req_of(v[36], v[35:32]),
               $sformatf("row %0d reg1", i), clk_en1, v[15:0]);
      end

      // R9: valid low, command fields present, nothing changes
      hold0 = clk_en0;
      @(negedge clk);
      legacy_mode = 1'b0; cmd_valid = 1'b0; cmd_supply = 1'b1; cmd_id = 4'd0;
      @(negedge clk);
      check("R9", "no strobe no change", clk_en0, hold0);

      // R11: direct writes and reads
      do_write(3'd0, 16'h00F0, 1'b0, 4'd0);
      check("R11", "write reg0 output", clk_en0, 16'h00F0);
      reg_addr = 3'd0; #0.1;
      check("R11", "read reg0", reg_rdata, 16'h00F0);
      do_write(3'd4, 16'h0003, 1'b0, 4'd0);
      check("R11", "write reg1 output", clk_en1, 16'h0003);
      reg_addr = 3'd4; #0.1;
      check("R11", "read reg1", reg_rdata, 16'h0003);
      do_write(3'd2, 16'hFFFF, 1'b0, 4'd0);
      check("R11", "unmapped write reg0", clk_en0, 16'h00F0);
      check("R11", "unmapped write reg1", clk_en1, 16'h0003);
      reg_addr = 3'd2; #0.1;
      check("R11", "unmapped read", reg_rdata, 16'h0000);

      // R12: write beats a simultaneous command
      do_write(3'd0, 16'h1234, 1'b1, 4'd0);
      check("R12", "reg0 write over touch cmd", clk_en0, 16'h1234);
      do_write(3'd4, 16'h0008, 1'b1, 4'd10);
      check("R12", "reg1 write over camera cmd", clk_en1, 16'h0008);

      // R10: entering legacy clears reg1; writes ignored
      @(negedge clk);
      legacy_mode = 1'b1;
      @(negedge clk);
      check("R10", "reg1 cleared on legacy", clk_en1, 16'h0000);
      do_write(3'd4, 16'h0007, 1'b0, 4'd0);
      check("R10", "legacy write reg1 output", clk_en1, 16'h0000);
      reg_addr = 3'd4; #0.1;
      check("R10", "legacy read reg1", reg_rdata, 16'h0000);
      check("R10", "reg0 untouched", clk_en0, 16'h1234);

      // R1: reset mid-run
      @(negedge clk);
      legacy_mode = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1", "en0 after mid reset", clk_en0, 16'h0000);
      check("R1", "en1 after mid reset", clk_en1, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule